// File: doc/BRIEF.md
# Two-Tier Thread Fetch and Issue Arbiter

This block decides, every clock cycle, which hardware thread of a simultaneously multithreaded core may fetch instructions and which may issue. Some of the threads are marked as favoured by a programmable mask. Favoured threads get fetch bandwidth whenever their prefetch buffer can take more. Favoured threads also get the issue slot whenever they are able to issue. The other threads are served only when no favoured thread can use the resource. This keeps single-thread speed high for the favoured threads, and it lets the other threads fill the cycles that would otherwise be lost.

Each cycle the block samples one buffer-full flag and one stall flag per thread. It produces a registered one-hot fetch grant and a registered one-hot issue grant. Within the chosen tier, each function keeps its own rotating pointer, so that the eligible threads take turns. The favoured mask is held in a register that is loaded through a one-cycle write strobe. The thread count is a parameter in the range four to eight. Two to four favoured threads is the expected use.

Top module: `smt_pref_arb`

## Requirements
- R1: When at least one favoured thread (mask bit i = 1 for thread i) has `full_i[i]` = 0, the fetch grant goes to a favoured thread whose buffer is not full.
- R2: A thread that is not favoured receives a fetch grant only if every favoured thread has `full_i` = 1 in the sampled cycle.
- R3: The issue grant goes to a favoured thread with `stall_i` = 0 whenever one exists. A thread that is not favoured receives the issue grant only if every favoured thread is stalled.
- R4: Within the selected tier, the search starts at the thread index held in that function's pointer and moves upward with wrap-around. The first eligible thread wins. Full threads (for fetch) and stalled threads (for issue) are skipped.
- R5: After a grant to thread k, the pointer of that function becomes k+1 (wrapping to 0 after N-1). A cycle with no grant leaves the pointer unchanged.
- R6: Each grant vector has at most one bit set. When no thread is eligible, the grant vector is all zeros.
- R7: Grants are registered. Flags sampled at clock edge t are reflected in the grants visible after edge t, and the grants hold steady until the next edge.
- R8: When `pmask_we` = 1, `pmask_wdata` is loaded at that edge. Grants registered at that same edge still use the old mask. Grants registered at the next edge use the new mask.
- R9: While synchronous reset is asserted, both grants are zero, both pointers are 0, and the mask takes the value of parameter PREF_RST (default: threads 0 to 3 favoured).
- R10: A thread that is both full and stalled receives neither a fetch grant nor an issue grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_i | input | N | Per-thread prefetch buffer full flag, bit i = thread i |
| stall_i | input | N | Per-thread stall flag, bit i = thread i |
| pmask_we | input | 1 | Write strobe for the favoured-thread mask |
| pmask_wdata | input | N | New favoured-thread mask, bit i = thread i |
| fetch_gnt | output | N | Registered one-hot fetch grant |
| issue_gnt | output | N | Registered one-hot issue grant |

## Verification
Every grant appears one edge after the flags it was computed from. A mask write only affects the grants one edge later still. The bench drives its stimulus on the falling edge, lets exactly one rising edge pass, and compares both grants on the next falling edge. The comparison is made against a model that keeps its own copy of the two pointers and of the mask. One check samples the grants after the inputs have changed but before the next rising edge, to confirm that they still show the previous decision.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;

  // Advance a rotating pointer past a granted index, wrapping at n.
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/smt_rr_pick.sv
module smt_rr_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          hit
);

  // Scan from ptr upward, wrapping, first requester wins.
  always_comb begin
    gnt = '0;
    idx = '0;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!hit && req[j]) begin
        hit    = 1'b1;
        gnt[j] = 1'b1;
        idx    = IW'(j);
      end
    end
  end

endmodule

// File: rtl/smt_tier_sel.sv
module smt_tier_sel #(
  parameter int N = 8
) (
  input  logic [N-1:0] elig,
  input  logic [N-1:0] pref,
  output logic [N-1:0] req
);

  logic [N-1:0] hi_req;
  logic [N-1:0] lo_req;

  assign hi_req = elig & pref;
  assign lo_req = elig & ~pref;

  // Favoured tier wins outright whenever any of its members can go.
  assign req = (|hi_req) ? hi_req : lo_req;

endmodule

// File: rtl/smt_arb_lane.sv
module smt_arb_lane #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] elig,
  input  logic [N-1:0] pref,
  output logic [N-1:0] gnt_q
);
  import smt_arb_pkg::*;

  logic [N-1:0]  req;
  logic [N-1:0]  gnt_d;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win_idx;
  logic          win_hit;

  smt_tier_sel #(.N(N)) u_tier (
    .elig (elig),
    .pref (pref),
    .req  (req)
  );

  smt_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req (req),
    .ptr (ptr_q),
    .gnt (gnt_d),
    .idx (win_idx),
    .hit (win_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      gnt_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      if (win_hit) ptr_q <= IW'(wrap_next(int'(win_idx), N));
    end
  end

endmodule

// File: rtl/smt_pref_reg.sv
module smt_pref_reg #(
  parameter int           N        = 8,
  parameter logic [N-1:0] PREF_RST = 8'h0F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pref_q
);

  always_ff @(posedge clk) begin
    if (rst)     pref_q <= PREF_RST;
    else if (we) pref_q <= wdata;
  end

endmodule

// File: rtl/smt_pref_arb.sv
module smt_pref_arb #(
  parameter int           N        = 8,
  parameter logic [N-1:0] PREF_RST = 8'h0F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] full_i,
  input  logic [N-1:0] stall_i,
  input  logic         pmask_we,
  input  logic [N-1:0] pmask_wdata,
  output logic [N-1:0] fetch_gnt,
  output logic [N-1:0] issue_gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int NLANE = 2;

  logic [N-1:0] pref_q;
  logic [N-1:0] lane_elig [NLANE];
  logic [N-1:0] lane_gnt  [NLANE];

  smt_pref_reg #(.N(N), .PREF_RST(PREF_RST)) u_pref (
    .clk    (clk),
    .rst    (rst),
    .we     (pmask_we),
    .wdata  (pmask_wdata),
    .pref_q (pref_q)
  );

  // Lane 0 arbitrates fetch (needs buffer room), lane 1 issue (needs no stall).
  assign lane_elig[0] = ~full_i;
  assign lane_elig[1] = ~stall_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    smt_arb_lane #(.N(N), .IW(IW)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .elig  (lane_elig[g]),
      .pref  (pref_q),
      .gnt_q (lane_gnt[g])
    );
  end

  assign fetch_gnt = lane_gnt[0];
  assign issue_gnt = lane_gnt[1];

endmodule

// File: rtl/smt_pref_arb_chk.sv
module smt_pref_arb_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] full_i,
  input logic [N-1:0] stall_i,
  input logic [N-1:0] fetch_gnt,
  input logic [N-1:0] issue_gnt,
  input logic [N-1:0] pref_q
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_FETCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fetch_gnt)); // R6

  AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_gnt)); // R6

  AST_FETCH_ROOM: assert property (@(posedge clk) disable iff (rst || !past_ok)
    |fetch_gnt |-> ((fetch_gnt & $past(full_i)) == '0)); // R1

  AST_FETCH_TIER: assert property (@(posedge clk) disable iff (rst || !past_ok)
    |(fetch_gnt & ~$past(pref_q)) |-> (($past(full_i) | ~$past(pref_q)) == '1)); // R2

  AST_ISSUE_TIER: assert property (@(posedge clk) disable iff (rst || !past_ok)
    |(issue_gnt & ~$past(pref_q)) |-> (($past(stall_i) | ~$past(pref_q)) == '1)); // R3

  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    |issue_gnt |-> ((issue_gnt & $past(stall_i)) == '0)); // R3

  AST_BOTH_BLOCKED: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (((fetch_gnt | issue_gnt) & $past(full_i) & $past(stall_i)) == '0)); // R10

endmodule

bind smt_pref_arb smt_pref_arb_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .full_i    (full_i),
  .stall_i   (stall_i),
  .fetch_gnt (fetch_gnt),
  .issue_gnt (issue_gnt),
  .pref_q    (pref_q)
);

// File: tb/sim_smt_pref_arb.sv
module sim_smt_pref_arb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] full_i = '0;
  logic [N-1:0] stall_i = '0;
  logic         pmask_we = 1'b0;
  logic [N-1:0] pmask_wdata = '0;
  logic [N-1:0] fetch_gnt;
  logic [N-1:0] issue_gnt;

  int errors = 0;
  int checks = 0;

  // Model state
  logic [N-1:0] m_pref = 8'h0F;
  int           m_fptr = 0;
  int           m_iptr = 0;

  always #5 clk = ~clk;

  smt_pref_arb #(.N(N), .PREF_RST(8'h0F)) u0 (
    .clk(clk), .rst(rst), .full_i(full_i), .stall_i(stall_i),
    .pmask_we(pmask_we), .pmask_wdata(pmask_wdata),
    .fetch_gnt(fetch_gnt), .issue_gnt(issue_gnt)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Two-tier rotating pick; updates the given pointer on a grant.
  function automatic logic [N-1:0] model_pick(input logic [N-1:0] elig,
                                               input logic [N-1:0] pref,
                                               inout int ptr);
    logic [N-1:0] req;
    logic [N-1:0] g;
    g = '0;
    req = ((elig & pref) != '0) ? (elig & pref) : (elig & ~pref);
    for (int k = 0; k < N; k++) begin
      int j;
      j = (ptr + k) % N;
      if (g == '0 && req[j]) g[j] = 1'b1;
    end
    for (int k = 0; k < N; k++) if (g[k]) ptr = (k + 1) % N;
    return g;
  endfunction

  // One cycle: drive at falling edge, model at rising edge, compare at next falling edge.
  task automatic step(input string tag, input logic [N-1:0] f, input logic [N-1:0] s,
                      input logic we = 1'b0, input logic [N-1:0] wd = '0);
    logic [N-1:0] ef;
    logic [N-1:0] ei;
    full_i = f; stall_i = s; pmask_we = we; pmask_wdata = wd;
    @(posedge clk);
    ef = model_pick(~f, m_pref, m_fptr);
    ei = model_pick(~s, m_pref, m_iptr);
    if (we) m_pref = wd;
    @(negedge clk);
    pmask_we = 1'b0;
    chk({tag, " fetch"}, fetch_gnt, ef);
    chk({tag, " issue"}, issue_gnt, ei);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 fetch at reset", fetch_gnt, '0);
    chk("R9 issue at reset", issue_gnt, '0);
    rst = 1'b0;
    m_pref = 8'h0F; m_fptr = 0; m_iptr = 0;
    step("R9 first grant thread0", '0, '0);
    chk("R9 pointer starts at 0", fetch_gnt, 8'h01);
  endtask

  task automatic t_rotate;
    for (int i = 0; i < 5; i++) step("R1 R4 favoured rotation", '0, '0);
    step("R4 skip full favoured", 8'h0B, 8'h00);
    chk("R4 only thread2 has room", fetch_gnt, 8'h04);
  endtask

  task automatic t_nonpref_fetch;
    for (int i = 0; i < 5; i++) step("R2 favoured all full", 8'h0F, '0);
    step("R2 back to favoured", 8'h07, '0);
    chk("R2 thread3 regains fetch", fetch_gnt, 8'h08);
  endtask

  task automatic t_issue;
    for (int i = 0; i < 4; i++) step("R3 favoured all stalled", '0, 8'h0F);
    step("R3 one favoured free", '0, 8'h07);
    chk("R3 thread3 issues", issue_gnt, 8'h08);
  endtask

  task automatic t_blocked;
    for (int i = 0; i < 4; i++) step("R10 thread4 full and stalled", 8'h1F, 8'h1F);
  endtask

  task automatic t_none;
    step("R6 nothing eligible", '1, '1);
    chk("R6 fetch zero", fetch_gnt, '0);
    step("R5 pointer held", 8'h7F, 8'h7F);
    chk("R5 thread7 only", fetch_gnt, 8'h80);
    step("R5 after idle cycles", '0, '0);
  endtask

  task automatic t_latency;
    step("R7 setup", 8'h0E, '0);
    full_i = 8'h0D;
    #2;
    chk("R7 output held before edge", fetch_gnt, 8'h01);
  endtask

  task automatic t_mask;
    step("R8 write cycle uses old mask", '0, '0, 1'b1, 8'hF0);
    for (int i = 0; i < 4; i++) step("R8 new mask in force", '0, '0);
    step("R8 new mask favoured full", 8'hF0, 8'hF0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rotate();
    t_nonpref_fetch();
    t_issue();
    t_blocked();
    t_none();
    t_latency();
    t_mask();
    finish_run();
  end

endmodule